// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive request lines from peripherals and presents them to a processor core as two combined lines. One line is for fast requests and one is for normal requests. A per-source class bit decides which of the two lines a source feeds. A per-source enable bit gates the source. A per-source software bit can raise a source with no hardware activity. The fast and normal lines are registered, so each one follows its status one clock later.

Normal-class requests can be vectored. Sixteen slots each bind one source channel to a handler address, and a lower slot number means a higher priority. When the core reads the vector register, the block returns the handler address of the winning slot. If a normal request is active but no enabled slot is bound to it, the block returns a programmable fallback address. The same read marks the returned priority level as in service. That level and every level below it stay masked until end of interrupt, while higher-priority slots can still preempt. Any write to the vector register is the end-of-interrupt and retires the highest-priority level in service. Software programs the block over a simple word-addressed register bus. The bus carries one access per cycle, and read data appears one cycle after the read strobe.

Top module: `vic_top`

## Requirements
- R1: After reset every register reads zero, `bus_rdata_o` is zero, `fiq_o` and `irq_o` are low, and no level is in service.
- R2: Bit n of the class register (offset 0x00, read/write) at 1 routes source n to the fast status (offset 0x07); at 0 it routes the source to the normal status (offset 0x06). Fast-class sources never take part in vectoring.
- R3: Writing offset 0x01 sets the enable bits written as 1. Writing offset 0x02 clears the enable bits written as 1. Zero bits in either write leave enables unchanged. Reading 0x01 returns the enables, and reading 0x02 returns zero.
- R4: Writing offset 0x03 sets software request bits, and writing offset 0x04 clears those written as 1. The raw status (offset 0x05, read-only; writes ignored) is the OR of `src_i` and the software bits, before enable masking.
- R5: Each status bit is raw AND enable AND class. `fiq_o` and `irq_o` are the OR of the fast and normal status as it stood before the previous clock edge, one cycle of latency.
- R6: Slot control register k is at offset 0x10+k and holds the channel in bits [4:0] and a slot-enable flag in bit 5. Only these 6 bits are stored. Slot address register k is at offset 0x20+k. The fallback address is at offset 0x09.
- R7: A vector read (offset 0x08) returns the address of the lowest-numbered enabled slot whose channel has active normal status and whose level is above the current in-service level.
- R8: When no slot qualifies, the vector read returns the fallback address. It marks the fallback level (below all slots) in service only if an active normal source is bound to no enabled slot and nothing is in service. Otherwise it marks nothing.
- R9: A vector read that wins marks that level in service. Repeat reads then cannot return that slot or lower ones, but can return higher slots.
- R10: Any write to offset 0x08, whatever its data, retires the highest-priority level in service. A write with nothing in service has no effect.
- R11: `bus_rdata_o` loads on the edge where `bus_rd_i` is high, with the value the addressed register had before that edge, and holds while `bus_rd_i` is low. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level request lines, synchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Word offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| fiq_o | output | 1 | Combined fast request to the core |
| irq_o | output | 1 | Combined normal request to the core |

## Verification
The bench targets three kinds of error: priority among slots, preemption and in-service masking, and the fallback rules.
- A design that scans the slots from the wrong end would return the higher-numbered slot when two slots are active. A design that does not mask the level in service would return the same slot again on a repeat read.
- A design that gets end-of-interrupt wrong would retire the wrong level or would let a lower slot back in too early. The bench checks for both.
- The fallback cases include an unslotted source, a slot whose enable flag is off, and an empty read. A design that latches on an empty read, or that lets the fallback preempt, is exposed by the vector reads that follow.
- Write data full of zeros to the enable and software registers, writes to the read-only raw register, and fast-class sources bound to a slot each expose a design that lets a don't-care input leak into state.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DATA_W = 32;
  localparam int CHAN_W = 5;
  localparam int CTL_W  = CHAN_W + 1;

  localparam logic [7:0] OFS_CLASS  = 8'h00;
  localparam logic [7:0] OFS_ENSET  = 8'h01;
  localparam logic [7:0] OFS_ENCLR  = 8'h02;
  localparam logic [7:0] OFS_SWSET  = 8'h03;
  localparam logic [7:0] OFS_SWCLR  = 8'h04;
  localparam logic [7:0] OFS_RAW    = 8'h05;
  localparam logic [7:0] OFS_IRQST  = 8'h06;
  localparam logic [7:0] OFS_FIQST  = 8'h07;
  localparam logic [7:0] OFS_VECT   = 8'h08;
  localparam logic [7:0] OFS_FALLBK = 8'h09;
  localparam logic [7:0] OFS_CTL0   = 8'h10;
  localparam logic [7:0] OFS_ADR0   = 8'h20;
endpackage

// File: rtl/vic_src_regs.sv
module vic_src_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_i,
  input  logic [7:0]         addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] class_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] soft_q,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] irq_st_o,
  output logic [NUM_SRC-1:0] fiq_st_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_q <= '0;
      en_q    <= '0;
      soft_q  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_CLASS: class_q <= wdata_i;
        OFS_ENSET: en_q    <= en_q | wdata_i;
        OFS_ENCLR: en_q    <= en_q & ~wdata_i;
        OFS_SWSET: soft_q  <= soft_q | wdata_i;
        OFS_SWCLR: soft_q  <= soft_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  assign raw_o    = src_i | soft_q;
  assign irq_st_o = raw_o & en_q & ~class_q;
  assign fiq_st_o = raw_o & en_q & class_q;
endmodule

// File: rtl/vic_slot_table.sv
module vic_slot_table
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int VA_W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [7:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] irq_st_i,
  output logic [NUM_SLOT-1:0] slot_hit_o,
  output logic [VA_W-1:0]    slot_adr_o [NUM_SLOT],
  output logic [NUM_SRC-1:0] covered_o,
  output logic               tbl_sel_o,
  output logic [DATA_W-1:0]  tbl_rdata_o
);
  localparam int PAD_W = 1 << CHAN_W;

  logic [PAD_W-1:0] irq_pad;
  logic [PAD_W-1:0] cov_pad;
  logic [CTL_W-1:0] ctl_v [NUM_SLOT];

  assign irq_pad = PAD_W'(irq_st_i);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    localparam logic [7:0] CTL_OFS = OFS_CTL0 + 8'(s);
    localparam logic [7:0] ADR_OFS = OFS_ADR0 + 8'(s);
    logic [CTL_W-1:0] ctl_q;
    logic [VA_W-1:0]  adr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q <= '0;
        adr_q <= '0;
      end else if (wr_i) begin
        if (addr_i == CTL_OFS) ctl_q <= wdata_i[CTL_W-1:0];
        if (addr_i == ADR_OFS) adr_q <= wdata_i[VA_W-1:0];
      end
    end

    assign ctl_v[s]      = ctl_q;
    assign slot_adr_o[s] = adr_q;
    assign slot_hit_o[s] = ctl_q[CHAN_W] & irq_pad[ctl_q[CHAN_W-1:0]];
  end

  always_comb begin
    cov_pad = '0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (ctl_v[s][CHAN_W]) cov_pad[ctl_v[s][CHAN_W-1:0]] = 1'b1;
    end
  end

  assign covered_o = cov_pad[NUM_SRC-1:0];

  always_comb begin
    tbl_sel_o   = 1'b0;
    tbl_rdata_o = '0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (addr_i == OFS_CTL0 + 8'(s)) begin
        tbl_sel_o   = 1'b1;
        tbl_rdata_o = DATA_W'(ctl_v[s]);
      end
      if (addr_i == OFS_ADR0 + 8'(s)) begin
        tbl_sel_o   = 1'b1;
        tbl_rdata_o = DATA_W'(slot_adr_o[s]);
      end
    end
  end
endmodule

// File: rtl/vic_prio_nest.sv
module vic_prio_nest #(
  parameter int NUM_SLOT = 16,
  parameter int VA_W     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SLOT-1:0] slot_hit_i,
  input  logic [VA_W-1:0]     slot_adr_i [NUM_SLOT],
  input  logic [VA_W-1:0]     fallbk_adr_i,
  input  logic                unslot_pend_i,
  input  logic                vect_rd_i,
  input  logic                vect_wr_i,
  output logic [VA_W-1:0]     vect_data_o,
  output logic [NUM_SLOT:0]   ins_q
);
  localparam int NLVL = NUM_SLOT + 1;
  localparam int LW   = $clog2(NLVL + 1);
  localparam int SW   = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;

  logic [LW-1:0]   thr;
  logic            win_ok;
  logic [SW-1:0]   win_idx;
  logic            fb_ok;
  logic [NLVL-1:0] grant;
  logic [NLVL-1:0] retire;

  always_comb begin
    thr = LW'(NLVL);
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (ins_q[i]) thr = LW'(i);
    end
  end

  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (slot_hit_i[i] && (LW'(i) < thr)) begin
        win_ok  = 1'b1;
        win_idx = SW'(i);
      end
    end
  end

  assign fb_ok       = unslot_pend_i && (thr > LW'(NUM_SLOT));
  assign vect_data_o = win_ok ? slot_adr_i[win_idx] : fallbk_adr_i;

  always_comb begin
    grant = '0;
    if (win_ok)     grant[win_idx]  = 1'b1;
    else if (fb_ok) grant[NUM_SLOT] = 1'b1;
  end

  assign retire = ins_q & (~ins_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ins_q <= '0;
    else        ins_q <= (ins_q & ~(vect_wr_i ? retire : '0)) | (vect_rd_i ? grant : '0);
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int VA_W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [7:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               fiq_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0]  class_q, en_q, soft_q, raw, irq_st, fiq_st, covered;
  logic [NUM_SLOT-1:0] slot_hit;
  logic [VA_W-1:0]     slot_adr [NUM_SLOT];
  logic [VA_W-1:0]     fallbk_q, vect_data;
  logic [NUM_SLOT:0]   ins_q;
  logic                tbl_sel;
  logic [DATA_W-1:0]   tbl_rdata, rd_mux;
  logic                vect_rd, vect_wr;

  assign vect_rd = bus_rd_i && (bus_addr_i == OFS_VECT);
  assign vect_wr = bus_wr_i && (bus_addr_i == OFS_VECT);

  vic_src_regs #(.NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i[NUM_SRC-1:0]),
    .class_q(class_q), .en_q(en_q), .soft_q(soft_q),
    .raw_o(raw), .irq_st_o(irq_st), .fiq_st_o(fiq_st)
  );

  vic_slot_table #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .VA_W(VA_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .irq_st_i(irq_st), .slot_hit_o(slot_hit), .slot_adr_o(slot_adr),
    .covered_o(covered), .tbl_sel_o(tbl_sel), .tbl_rdata_o(tbl_rdata)
  );

  vic_prio_nest #(.NUM_SLOT(NUM_SLOT), .VA_W(VA_W)) u_nest (
    .clk(clk), .rst_n(rst_n),
    .slot_hit_i(slot_hit), .slot_adr_i(slot_adr), .fallbk_adr_i(fallbk_q),
    .unslot_pend_i(|(irq_st & ~covered)),
    .vect_rd_i(vect_rd), .vect_wr_i(vect_wr),
    .vect_data_o(vect_data), .ins_q(ins_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   fallbk_q <= '0;
    else if (bus_wr_i && bus_addr_i == OFS_FALLBK) fallbk_q <= bus_wdata_i[VA_W-1:0];
  end

  always_comb begin
    case (bus_addr_i)
      OFS_CLASS:  rd_mux = DATA_W'(class_q);
      OFS_ENSET:  rd_mux = DATA_W'(en_q);
      OFS_SWSET:  rd_mux = DATA_W'(soft_q);
      OFS_RAW:    rd_mux = DATA_W'(raw);
      OFS_IRQST:  rd_mux = DATA_W'(irq_st);
      OFS_FIQST:  rd_mux = DATA_W'(fiq_st);
      OFS_VECT:   rd_mux = DATA_W'(vect_data);
      OFS_FALLBK: rd_mux = DATA_W'(fallbk_q);
      default:    rd_mux = tbl_sel ? tbl_rdata : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata_o <= '0;
      fiq_o       <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      if (bus_rd_i) bus_rdata_o <= rd_mux;
      fiq_o <= |fiq_st;
      irq_o <= |irq_st;
    end
  end
endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr_i,
  input logic               bus_rd_i,
  input logic [7:0]         bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic [31:0]        bus_rdata_o,
  input logic               fiq_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] raw,
  input logic [NUM_SLOT:0]  ins_q
);
  logic vrd, vwr;
  assign vrd = bus_rd_i && bus_addr_i == 8'h08;
  assign vwr = bus_wr_i && bus_addr_i == 8'h08;

  // R3: clearing every enable silences both core lines two edges later
  assert_all_clear_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 8'h02 && bus_wdata_i == 32'hFFFF_FFFF) |=> ##1 (!fiq_o && !irq_o));

  // R5: a core line can only be high if some raw request existed the edge before
  assert_line_needs_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o || irq_o) |-> $past(raw != '0));

  // R10: end-of-interrupt retires exactly one level when any is in service
  assert_eoi_retires_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vwr && !vrd && ins_q != '0) |=> ($countones(ins_q) + 1 == $past($countones(ins_q))));

  // R9: a vector read adds at most one level, and only above the current one
  assert_grant_above_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd && !vwr) |=> (((ins_q & ~$past(ins_q)) == '0) || ($past(ins_q) == '0) ||
      (((ins_q & ~$past(ins_q)) < ($past(ins_q) & (~$past(ins_q) + 1'b1))) &&
       ($countones(ins_q) == $past($countones(ins_q)) + 1))));

  // R9: in-service state moves only on vector accesses
  assert_ins_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!vrd && !vwr) |=> $stable(ins_q));

  // R11: read data holds when no read is strobed
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

bind vic_top vic_top_chk #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .fiq_o(fiq_o), .irq_o(irq_o), .raw(raw), .ins_q(ins_q)
);

// File: tb/vic_top_tb.sv
module vic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  vic_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .fiq_o(fiq), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_cls = '0, m_en = '0, m_sw = '0, m_fb = '0, m_rd = '0;
  logic [5:0]  m_ctl [16];
  logic [31:0] m_adr [16];
  logic [16:0] m_ins = '0;
  logic        m_fiq = 1'b0, m_irq = 1'b0;

  always @(posedge clk) begin
    logic [31:0] rw, ist, fst, cov, rv;
    logic [16:0] gnt, pop;
    int lvl, win;
    if (!rst_n) begin
      m_cls = '0; m_en = '0; m_sw = '0; m_fb = '0; m_rd = '0; m_ins = '0;
      m_fiq = 1'b0; m_irq = 1'b0;
      for (int k = 0; k < 16; k++) begin m_ctl[k] = '0; m_adr[k] = '0; end
    end else begin
      rw  = src | m_sw;
      ist = rw & m_en & ~m_cls;
      fst = rw & m_en & m_cls;
      lvl = 17;
      for (int k = 16; k >= 0; k--) if (m_ins[k]) lvl = k;
      cov = '0; win = -1;
      for (int k = 15; k >= 0; k--)
        if (m_ctl[k][5]) begin
          cov[m_ctl[k][4:0]] = 1'b1;
          if (ist[m_ctl[k][4:0]] && k < lvl) win = k;
        end
      gnt = '0;
      if (win >= 0) gnt[win] = 1'b1;
      else if ((ist & ~cov) != 0 && lvl > 16) gnt[16] = 1'b1;
      if (addr >= 8'h10 && addr < 8'h20)      rv = {26'b0, m_ctl[addr - 8'h10]};
      else if (addr >= 8'h20 && addr < 8'h30) rv = m_adr[addr - 8'h20];
      else case (addr)
        8'h00: rv = m_cls;  8'h01: rv = m_en;  8'h03: rv = m_sw;
        8'h05: rv = rw;     8'h06: rv = ist;   8'h07: rv = fst;
        8'h08: rv = (win >= 0) ? m_adr[win] : m_fb;
        8'h09: rv = m_fb;
        default: rv = '0;
      endcase
      if (rd) m_rd = rv;
      m_fiq = |fst; m_irq = |ist;
      pop = m_ins & (~m_ins + 1'b1);
      if (wr && addr == 8'h08) m_ins = m_ins & ~pop;
      if (rd && addr == 8'h08) m_ins = m_ins | gnt;
      if (wr) begin
        if (addr >= 8'h10 && addr < 8'h20)      m_ctl[addr - 8'h10] = wdata[5:0];
        else if (addr >= 8'h20 && addr < 8'h30) m_adr[addr - 8'h20] = wdata;
        else case (addr)
          8'h00: m_cls = wdata;
          8'h01: m_en  = m_en | wdata;
          8'h02: m_en  = m_en & ~wdata;
          8'h03: m_sw  = m_sw | wdata;
          8'h04: m_sw  = m_sw & ~wdata;
          8'h09: m_fb  = wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (fiq !== m_fiq || irq !== m_irq || rdata !== m_rd) begin
        n_bad++;
        $display("FAIL %s cycle compare: fiq/irq/rdata act %b/%b/%h exp %b/%b/%h",
                 tag, fiq, irq, rdata, m_fiq, m_irq, m_rd);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s directed: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rchk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); rd = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic ochk(input logic ef, input logic ei, input string req);
    @(negedge clk);
    chk(req, {30'b0, fiq, irq}, {30'b0, ef, ei});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: act hung exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    chk("R1", rdata, 32'h0);
    chk("R1", {30'b0, fiq, irq}, 32'h0);
    rchk(8'h00, 32'h0, "R1");
    rchk(8'h01, 32'h0, "R1");
    rchk(8'h08, 32'h0, "R1");
    rchk(8'h25, 32'h0, "R1");

    // R2 R3 R5 classification, enables, registered lines
    tag = "R3";
    src = 32'h10;
    ochk(1'b0, 1'b0, "R3");
    wreg(8'h01, 32'h10);
    chk("R5", {31'b0, irq}, 32'h0);          // still one edge behind
    ochk(1'b0, 1'b1, "R5");
    rchk(8'h06, 32'h10, "R2");
    tag = "R2";
    wreg(8'h00, 32'h10);
    ochk(1'b1, 1'b0, "R2");
    rchk(8'h07, 32'h10, "R2");
    rchk(8'h06, 32'h0, "R2");
    tag = "R3";
    wreg(8'h01, 32'h0);
    wreg(8'h02, 32'h0);
    ochk(1'b1, 1'b0, "R3");
    rchk(8'h02, 32'h0, "R3");
    wreg(8'h02, 32'h10);
    ochk(1'b0, 1'b0, "R3");
    rchk(8'h01, 32'h0, "R3");
    wreg(8'h00, 32'h0);

    // R4 software requests and raw status
    tag = "R4";
    src = 32'h0;
    wreg(8'h01, 32'h100);
    wreg(8'h03, 32'h100);
    rchk(8'h05, 32'h100, "R4");
    ochk(1'b0, 1'b1, "R4");
    wreg(8'h04, 32'h0);
    rchk(8'h03, 32'h100, "R4");
    wreg(8'h05, 32'hFFFF);
    rchk(8'h05, 32'h100, "R4");
    wreg(8'h04, 32'h100);
    rchk(8'h05, 32'h0, "R4");
    ochk(1'b0, 1'b0, "R4");
    src = 32'h2;
    rchk(8'h05, 32'h2, "R4");
    src = 32'h0;

    // R6 slot programming
    tag = "R6";
    wreg(8'h09, 32'hD000_0000);
    wreg(8'h10, 32'h23);  wreg(8'h20, 32'hA000_0000);
    wreg(8'h11, 32'h27);  wreg(8'h21, 32'hA000_0001);
    wreg(8'h12, 32'h09);  wreg(8'h22, 32'hA000_0002);
    wreg(8'h15, 32'hFF);
    rchk(8'h10, 32'h23, "R6");
    rchk(8'h15, 32'h3F, "R6");
    rchk(8'h21, 32'hA000_0001, "R6");
    rchk(8'h09, 32'hD000_0000, "R6");
    wreg(8'h15, 32'h0);
    wreg(8'h01, 32'h288);

    // R7 priority
    tag = "R7";
    src = 32'h80;
    rchk(8'h08, 32'hA000_0001, "R7");
    wreg(8'h08, 32'h0);
    src = 32'h88;
    rchk(8'h08, 32'hA000_0000, "R7");
    wreg(8'h08, 32'h0);
    wreg(8'h00, 32'h8);                       // source 3 fast: slot 0 drops out
    rchk(8'h08, 32'hA000_0001, "R2");
    wreg(8'h08, 32'h0);
    wreg(8'h00, 32'h0);

    // R8 fallback
    tag = "R8";
    src = 32'h200;                            // slot 2 disabled: unslotted
    rchk(8'h08, 32'hD000_0000, "R8");
    src = 32'h280;
    rchk(8'h08, 32'hA000_0001, "R8");         // slot preempts fallback level
    rchk(8'h08, 32'hD000_0000, "R8");
    wreg(8'h08, 32'h0);
    wreg(8'h08, 32'h0);
    src = 32'h0;
    rchk(8'h08, 32'hD000_0000, "R8");         // empty read latches nothing
    wreg(8'h08, 32'h0);
    src = 32'h80;
    rchk(8'h08, 32'hA000_0001, "R8");
    wreg(8'h08, 32'h0);

    // R9 nesting and masking
    tag = "R9";
    rchk(8'h08, 32'hA000_0001, "R9");
    rchk(8'h08, 32'hD000_0000, "R9");         // own level masked
    src = 32'h88;
    rchk(8'h08, 32'hA000_0000, "R9");         // higher slot preempts
    rchk(8'h08, 32'hD000_0000, "R9");

    // R10 end of interrupt
    tag = "R10";
    wreg(8'h08, 32'h1234_5678);               // retires slot 0 only
    rchk(8'h08, 32'hA000_0000, "R10");
    wreg(8'h08, 32'h0);
    wreg(8'h08, 32'hFFFF_FFFF);               // retires slot 1
    src = 32'h80;
    rchk(8'h08, 32'hA000_0001, "R10");
    wreg(8'h08, 32'h0);
    wreg(8'h08, 32'h0);                       // nothing in service
    rchk(8'h08, 32'hA000_0001, "R10");
    wreg(8'h08, 32'h0);
    src = 32'h0;

    // R11 read hold and unmapped offsets
    tag = "R11";
    rchk(8'h21, 32'hA000_0001, "R11");
    repeat (3) @(negedge clk);
    chk("R11", rdata, 32'hA000_0001);
    rchk(8'h3F, 32'h0, "R11");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule